// File: doc/BRIEF.md
# Wear-Aware Unary Tick Counter Controller

This controller keeps an event counter that survives power loss. The count lives in one erase block of flash-like memory as a unary code: every increment clears one more bit, starting from the most significant bit of word 0 and moving toward the last bit of the last word. Program operations can only turn ones into zeros, so increments never need an erase. The block is erased only when the counter is cleared from a nonzero value.

After reset the controller rebuilds the count from memory. It scans the words in address order and stops at the first word that is not all zeros. It then adds the leading zeros found inside that word. An increment is a read-modify-write of the single word that holds the next bit.

The word size, the number of words and the program-count limit per word are parameters. If an increment would program a word past its limit, the controller refuses the write and raises an error flag. An increment at the top of the range raises a saturation flag and does not touch memory.

Top module: `uflash_tick_ctrl`

## Requirements
- R1: After reset, `busy` is high while the controller reads words from address 0 upward. It stops after the first word that is not all zeros, or after the last word. It then sets `count` to WORD_W times the number of all-zero words, plus the leading zeros of the word where it stopped, and lowers `busy`.
- R2: A region that reads as all ones gives a count of 0. `count` never exceeds TOTAL = WORD_W*NUM_WORDS.
- R3: An increment with count c below TOTAL does the following. It reads word c/WORD_W and programs that same word with the value read, minus bit (WORD_W-1 - c mod WORD_W), where bit WORD_W-1 is the MSB. It then sets count to c+1. It issues no erase.
- R4: If the word read for an increment already holds MAX_PROGS or more zero bits, the controller does not program it. It sets `wear_err` and leaves `count` unchanged.
- R5: A clear with a nonzero count issues exactly one erase. Afterwards the region reads all ones and `count` is 0.
- R6: A clear when `count` is already 0 issues no memory operation.
- R7: An increment when `count` equals TOTAL sets `saturated`. It issues no memory operation, leaves `count` unchanged, and `busy` stays low.
- R8: `busy` goes high on the clock edge that accepts a command and stays high until the memory port completes the last operation. `inc_req` and `clr_req` have no effect while `busy` is high.
- R9: Accepting a command first clears `saturated` and `wear_err`, so each flag reports the outcome of the latest command. When `inc_req` and `clr_req` are high together, the clear is taken.
- R10: Memory port protocol:
  - `mem_op` encodes read as 0, program as 1 and erase as 2.
  - `mem_req` with its `mem_op`, `mem_addr` and `mem_wdata` holds steady until the one-cycle `mem_done` pulse.
  - Read data is valid on `mem_rdata` during that pulse.
  - `mem_req` drops at the edge that sees `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the recovery scan |
| inc_req | input | 1 | Increment command, sampled when not busy |
| clr_req | input | 1 | Clear command, sampled when not busy; wins over increment |
| busy | output | 1 | Scan or command in progress |
| count | output | CNT_W | Recovered and maintained count, 0 to TOTAL |
| saturated | output | 1 | Last increment found the count full |
| wear_err | output | 1 | Last increment was refused by the program-count limit |
| mem_req | output | 1 | Memory operation request, held until done |
| mem_op | output | 2 | 0 read, 1 program, 2 erase |
| mem_addr | output | ADDR_W | Word address for read and program |
| mem_wdata | output | WORD_W | Program data (ones leave bits untouched) |
| mem_rdata | input | WORD_W | Read data, valid with mem_done |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
Two states are hard to reach by driving increments alone: a count recovered from deep inside the region, and a full region. Reaching either would take dozens of increments, and the wear limit would stop the run first. The bench therefore loads the memory model directly with chosen contents, such as a partly cleared third word or all zeros, and then pulses reset. This exercises the scan's stopping rules and the saturation path in a few cycles. The wear refusal is reached by running the bench with a program limit lower than the word width and incrementing one word up to that limit.

// File: rtl/uflash_pkg.sv
package uflash_pkg;
  typedef enum logic [1:0] {
    MOP_READ  = 2'd0,
    MOP_PROG  = 2'd1,
    MOP_ERASE = 2'd2
  } mop_e;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_IDLE,
    ST_INC_RD,
    ST_INC_PG,
    ST_ERASE
  } ctl_st_e;
endpackage

// File: rtl/uflash_word_eval.sv
// Per-word analysis: all-zero detect, leading zeros from the MSB, zero total.
module uflash_word_eval #(
  parameter int WORD_W = 8,
  localparam int LZ_W = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  output logic              all_zero,
  output logic [LZ_W-1:0]   lead_zeros,
  output logic [LZ_W-1:0]   zero_total
);
  logic hit;

  always_comb begin
    lead_zeros = '0;
    zero_total = '0;
    hit        = 1'b0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (!word[i]) zero_total = zero_total + LZ_W'(1);
      if (!hit) begin
        if (word[i]) hit = 1'b1;
        else         lead_zeros = lead_zeros + LZ_W'(1);
      end
    end
  end

  assign all_zero = ~|word;
endmodule

// File: rtl/uflash_bit_mask.sv
// One-hot mask of the bit to clear: offset 0 selects the MSB.
module uflash_bit_mask #(
  parameter int WORD_W = 8,
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic [OFF_W-1:0]  offset,
  output logic [WORD_W-1:0] mask
);
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    assign mask[g] = (offset == OFF_W'(WORD_W - 1 - g));
  end
endmodule

// File: rtl/uflash_tick_ctrl.sv
module uflash_tick_ctrl #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 4,
  parameter int MAX_PROGS = 8,
  localparam int TOTAL  = WORD_W * NUM_WORDS,
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int OFF_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_req,
  input  logic              clr_req,
  output logic              busy,
  output logic [CNT_W-1:0]  count,
  output logic              saturated,
  output logic              wear_err,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_done
);
  import uflash_pkg::*;

  localparam int LZ_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(TOTAL);
  localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(TOTAL - WORD_W);

  ctl_st_e state, state_d;

  logic              rd_all_zero;
  logic [LZ_W-1:0]   rd_lead;
  logic [LZ_W-1:0]   rd_zeros;
  logic [WORD_W-1:0] clr_mask;
  logic              port_fin, acc_clr, acc_inc, worn;
  logic [ADDR_W-1:0] word_idx;
  logic [OFF_W-1:0]  bit_off;

  uflash_word_eval #(.WORD_W(WORD_W)) u_eval (
    .word(mem_rdata), .all_zero(rd_all_zero),
    .lead_zeros(rd_lead), .zero_total(rd_zeros)
  );

  uflash_bit_mask #(.WORD_W(WORD_W)) u_mask (
    .offset(bit_off), .mask(clr_mask)
  );

  assign word_idx = count[OFF_W +: ADDR_W];
  assign bit_off  = count[OFF_W-1:0];
  assign port_fin = mem_req && mem_done;
  assign acc_clr  = (state == ST_IDLE) && clr_req;
  assign acc_inc  = (state == ST_IDLE) && inc_req && !clr_req;
  assign worn     = 32'(rd_zeros) >= MAX_PROGS;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_SCAN:
        if (port_fin && (!rd_all_zero || count == LAST_BASE)) state_d = ST_IDLE;
      ST_IDLE:
        if (acc_clr && count != '0)        state_d = ST_ERASE;
        else if (acc_inc && count != FULL) state_d = ST_INC_RD;
      ST_INC_RD:
        if (port_fin) state_d = worn ? ST_IDLE : ST_INC_PG;
      ST_INC_PG:
        if (port_fin) state_d = ST_IDLE;
      ST_ERASE:
        if (port_fin) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SCAN;
      busy  <= 1'b1;
    end else begin
      state <= state_d;
      busy  <= (state_d != ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_op    <= MOP_READ;
      mem_addr  <= '0;
      mem_wdata <= '1;
      count     <= '0;
      saturated <= 1'b0;
      wear_err  <= 1'b0;
    end else begin
      if (port_fin) begin
        mem_req <= 1'b0;
      end else if (!mem_req && state != ST_IDLE) begin
        mem_req  <= 1'b1;
        mem_addr <= word_idx;
        unique case (state)
          ST_INC_PG: mem_op <= MOP_PROG;
          ST_ERASE:  mem_op <= MOP_ERASE;
          default:   mem_op <= MOP_READ;
        endcase
      end

      unique case (state)
        ST_SCAN:
          if (port_fin) begin
            if (rd_all_zero) count <= count + CNT_W'(WORD_W);
            else             count <= count + CNT_W'(rd_lead);
          end
        ST_IDLE:
          if (acc_clr || acc_inc) begin
            wear_err  <= 1'b0;
            saturated <= acc_inc && (count == FULL);
          end
        ST_INC_RD:
          if (port_fin) begin
            if (worn) wear_err  <= 1'b1;
            else      mem_wdata <= mem_rdata & ~clr_mask;
          end
        ST_INC_PG:
          if (port_fin) count <= count + CNT_W'(1);
        ST_ERASE:
          if (port_fin) count <= '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uflash_tick_checks.sv
module uflash_tick_checks #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 4,
  localparam int TOTAL  = WORD_W * NUM_WORDS,
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [CNT_W-1:0]  count,
  input logic              saturated,
  input logic              mem_req,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_done
);
  p_req_inside_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(TOTAL));

  p_prog_steps_one_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_done && mem_op == 2'd1) |=> count == $past(count) + CNT_W'(1));

  p_erase_zeroes_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_done && mem_op == 2'd2) |=> count == '0);

  p_sat_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(saturated) |-> (count == CNT_W'(TOTAL) && !busy));

  p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_op) && $stable(mem_addr)));
endmodule

bind uflash_tick_ctrl uflash_tick_checks #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .count(count), .saturated(saturated),
  .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_done(mem_done)
);

// File: tb/tb_uflash_tick_ctrl.sv
module tb_uflash_tick_ctrl;
  localparam int W = 8;
  localparam int N = 4;
  localparam int M = 6;
  localparam int LAT = 2;
  localparam int CW = $clog2(W * N + 1);
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc_req = 1'b0, clr_req = 1'b0;
  logic busy, saturated, wear_err, mem_req, mem_done;
  logic [CW-1:0] count;
  logic [1:0] mem_op;
  logic [AW-1:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  uflash_tick_ctrl #(.WORD_W(W), .NUM_WORDS(N), .MAX_PROGS(M)) dut (
    .clk(clk), .rst(rst), .inc_req(inc_req), .clr_req(clr_req), .busy(busy),
    .count(count), .saturated(saturated), .wear_err(wear_err),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  // Nonvolatile memory model: program can only clear bits.
  logic [W-1:0] mem [N];
  int n_read = 0, n_prog = 0, n_erase = 0, n_raise = 0, n_badop = 0, lat_cnt = 0;
  initial begin
    mem_done = 1'b0;
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_req === 1'b1) begin
      if (mem_done) begin
        mem_done <= 1'b0;
        lat_cnt  <= 0;
      end else if (lat_cnt == LAT - 1) begin
        case (mem_op)
          2'd0: begin mem_rdata <= mem[mem_addr]; n_read <= n_read + 1; end
          2'd1: begin
            if ((mem_wdata & ~mem[mem_addr]) != '0) n_raise <= n_raise + 1;
            mem[mem_addr] <= mem[mem_addr] & mem_wdata;
            n_prog <= n_prog + 1;
          end
          2'd2: begin
            for (int i = 0; i < N; i++) mem[i] <= '1;
            n_erase <= n_erase + 1;
          end
          default: n_badop <= n_badop + 1;
        endcase
        mem_done <= 1'b1;
        lat_cnt  <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_done <= 1'b0;
      lat_cnt  <= 0;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    wait_idle();
  endtask

  task automatic pulse(input bit inc, input bit clr);
    @(negedge clk); inc_req = inc; clr_req = clr;
    @(negedge clk); inc_req = 1'b0; clr_req = 1'b0;
    wait_idle();
  endtask

  task automatic fill(input logic [W-1:0] a, b, c, d);
    mem[0] = a; mem[1] = b; mem[2] = c; mem[3] = d;
  endtask

  task automatic t_scan_erased();
    int r0;
    fill('1, '1, '1, '1);
    r0 = n_read;
    do_reset();
    check("R2 erased count", int'(count), 0);
    check("R1 busy after scan", int'(busy), 0);
    check("R1 scan reads", n_read - r0, 1);
    check("R9 flags at reset", int'({saturated, wear_err}), 0);
  endtask

  task automatic t_increments();
    for (int i = 0; i < 3; i++) pulse(1, 0);
    check("R3 count", int'(count), 3);
    check("R3 word0", int'(mem[0]), 'h1F);
    check("R3 programs", n_prog, 3);
    check("R3 no erase", n_erase, 0);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); inc_req = 1'b1;
    @(negedge clk);
    check("R8 busy after accept", int'(busy), 1);
    @(negedge clk);
    @(negedge clk); inc_req = 1'b0;
    wait_idle();
    check("R8 single increment", int'(count), 4);
    check("R8 programs", n_prog, 4);
  endtask

  task automatic t_wear();
    pulse(1, 0); pulse(1, 0);
    check("R4 reached limit", int'(count), 6);
    pulse(1, 0);
    check("R4 wear_err", int'(wear_err), 1);
    check("R4 count kept", int'(count), 6);
    check("R4 word kept", int'(mem[0]), 'h03);
    check("R4 no program", n_prog, 6);
  endtask

  task automatic t_clear();
    pulse(0, 1);
    check("R9 wear_err cleared", int'(wear_err), 0);
    check("R5 count zero", int'(count), 0);
    check("R5 one erase", n_erase, 1);
    check("R5 region ones", int'(mem[0] & mem[1] & mem[2] & mem[3]), 'hFF);
    pulse(0, 1);
    check("R6 no erase at zero", n_erase, 1);
  endtask

  task automatic t_scan_partial();
    int r0;
    fill('0, '0, 8'h07, '1);
    r0 = n_read;
    do_reset();
    check("R1 partial count", int'(count), 21);
    check("R1 partial reads", n_read - r0, 3);
    pulse(1, 0);
    check("R3 deep count", int'(count), 22);
    check("R3 deep word", int'(mem[2]), 'h03);
    check("R3 word3 untouched", int'(mem[3]), 'hFF);
  endtask

  task automatic t_saturate();
    int r0, p0;
    fill('0, '0, '0, '0);
    r0 = n_read;
    do_reset();
    check("R1 full count", int'(count), 32);
    check("R1 full reads", n_read - r0, 4);
    r0 = n_read; p0 = n_prog;
    @(negedge clk); inc_req = 1'b1;
    @(negedge clk); inc_req = 1'b0;
    check("R7 busy low", int'(busy), 0);
    wait_idle();
    check("R7 saturated", int'(saturated), 1);
    check("R7 count kept", int'(count), 32);
    check("R7 no memory op", (n_read - r0) + (n_prog - p0), 0);
    pulse(0, 1);
    check("R9 saturated cleared", int'(saturated), 0);
    check("R5 clear from full", int'(count), 0);
  endtask

  task automatic t_priority();
    int e0;
    pulse(1, 0);
    e0 = n_erase;
    pulse(1, 1);
    check("R9 clear wins", int'(count), 0);
    check("R9 erase issued", n_erase - e0, 1);
    check("R10 op codes valid", n_badop, 0);
    check("R10 no bit raised", n_raise, 0);
  endtask

  initial begin
    t_scan_erased();
    t_increments();
    t_busy_ignore();
    t_wear();
    t_clear();
    t_scan_partial();
    t_saturate();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule